// File: doc/BRIEF.md
# Interrupt thread-context group matcher

This block decides whether one incoming interrupt notification is aimed at a single hardware thread context. The context holds three privilege rings: physical hypervisor, hypervisor pool and operating system. Each ring has a valid bit, a context identifier, a group-enable byte and a current priority. The notification carries a target identifier, an ignore bit that turns the target into a group, a format bit and a priority.

Without the ignore bit, a ring matches only when its identifier equals the target exactly. With the ignore bit set, the target names a group. The group is aligned and its size comes from the run of one bits at the low end of the target. The low bits that this run covers, and the zero that ends it, are left out of the compare. A ring whose group-enable byte is zero takes no group notifications. Among the rings that are valid and match, the block picks the first in the fixed order physical, pool, OS. It then states whether the notification is precluded by that ring's current priority. A lower priority value means a more urgent interrupt.

The inputs are captured on a clock edge while the input strobe is high. The result appears on registered outputs one cycle later and holds until the next strobe.

Top module: `intr_ctx_matcher`

## Requirements
- R1: When the ignore bit is 0 and the format bit is 0, a valid ring matches only if its 32-bit identifier equals the target identifier in every bit.
- R2: When the ignore bit is 1, let t be the number of consecutive one bits starting at bit 0 of the target. Bits 0 through t are excluded from the compare, and all higher bits must be equal. An all-ones target therefore matches any identifier.
- R3: When several rings are valid and match, the reported ring index is the first in the order physical (code 0), pool (code 1), OS (code 2).
- R4: A ring whose valid bit is 0 never matches. Valid bit 0 belongs to physical, bit 1 to pool and bit 2 to OS. The identifier, group-enable and priority fields are packed the same way, ring 0 in the lowest slice.
- R5: For a group notification, a ring whose 8-bit group-enable byte is 0 is skipped even if its identifier matches. For an exact notification the group-enable byte has no effect.
- R6: On a hit, precluded is 1 unless the notification priority is strictly less than the matched ring's 8-bit current priority.
- R7: With no matching ring, the outputs are hit 0, ring index 3 (the no-match code) and precluded 0.
- R8: When the format bit is 1, no ring matches and the outputs are those of R7.
- R9: During and after reset, before any strobe, the outputs are out_valid 0, hit 0, ring index 3 and precluded 0.
- R10: The result for inputs captured at a rising edge with in_valid 1 appears after that edge. out_valid follows in_valid with one cycle of delay. While in_valid is 0, hit, ring index and precluded keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Capture strobe for a notification |
| fmt_i | input | 1 | Format bit; 1 selects the user-level path, which this block does not serve |
| ignore_i | input | 1 | 1 = group notification, 0 = exact notification |
| target_i | input | 32 | Target virtual-processor identifier |
| prio_i | input | 8 | Notification priority |
| ring_valid_i | input | 3 | Per-ring valid bits |
| ring_id_i | input | 96 | Per-ring context identifiers, 32 bits each |
| ring_lgs_i | input | 24 | Per-ring group-enable bytes |
| ring_cppr_i | input | 24 | Per-ring current priority, 8 bits each |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| hit_o | output | 1 | A ring matched |
| ring_idx_o | output | 2 | Matched ring code, 3 when no ring matched |
| precluded_o | output | 1 | The matched ring's priority blocks the notification |

## Verification
The bench builds the block with its default parameters: 32-bit identifiers, 8-bit priorities and three rings. At these values the ring codes fill the 2-bit index field, and code 3 is left free for no-match. The full identifier width lets the bench apply targets whose run of ones is short, long, or covers all 32 bits, so group sizes from 2 up to the whole identifier space are tested. Directed vectors that reach the same ring in several ways exercise the first-ring priority and the group-enable skip. Priorities equal to, one below and one above the current priority exercise the strict less-than boundary of the precluded flag.

// File: rtl/intr_ctx_matcher_pkg.sv
package intr_ctx_matcher_pkg;
  localparam int unsigned DEF_ID_W    = 32;
  localparam int unsigned DEF_PRIO_W  = 8;
  localparam int unsigned DEF_RINGS   = 3;
  localparam int unsigned RING_PHYS   = 0;
  localparam int unsigned RING_POOL   = 1;
  localparam int unsigned RING_OS     = 2;
endpackage

// File: rtl/icm_group_mask.sv
module icm_group_mask #(
  parameter int unsigned ID_W = 32
) (
  input  logic            group_i,
  input  logic [ID_W-1:0] target_i,
  output logic [ID_W-1:0] mask_o
);
  logic [ID_W-1:0] grp_mask;
  logic            zero_seen;

  // a bit survives the compare only if some lower bit of the target is zero
  always_comb begin
    zero_seen = 1'b0;
    grp_mask  = '0;
    for (int i = 0; i < int'(ID_W); i++) begin
      grp_mask[i] = zero_seen;
      if (!target_i[i]) zero_seen = 1'b1;
    end
  end

  assign mask_o = group_i ? grp_mask : {ID_W{1'b1}};
endmodule

// File: rtl/icm_ring_cmp.sv
module icm_ring_cmp #(
  parameter int unsigned ID_W   = 32,
  parameter int unsigned PRIO_W = 8
) (
  input  logic            group_i,
  input  logic [ID_W-1:0] target_i,
  input  logic [ID_W-1:0] mask_i,
  input  logic            valid_i,
  input  logic [ID_W-1:0] id_i,
  input  logic [7:0]      lgs_i,
  output logic            match_o
);
  logic id_eq;
  logic grp_blocked;

  assign id_eq       = ((target_i ^ id_i) & mask_i) == '0;
  assign grp_blocked = group_i && (lgs_i == 8'd0);
  assign match_o     = valid_i && !grp_blocked && id_eq;
endmodule

// File: rtl/icm_ring_pick.sv
module icm_ring_pick #(
  parameter int unsigned NUM_RINGS = 3,
  parameter int unsigned PRIO_W    = 8,
  localparam int unsigned IDX_W    = $clog2(NUM_RINGS + 1)
) (
  input  logic [NUM_RINGS-1:0]        match_i,
  input  logic [NUM_RINGS*PRIO_W-1:0] cppr_i,
  input  logic [PRIO_W-1:0]           prio_i,
  output logic                        hit_o,
  output logic [IDX_W-1:0]            idx_o,
  output logic                        prec_o
);
  localparam logic [IDX_W-1:0] NONE = IDX_W'(NUM_RINGS);

  logic [PRIO_W-1:0] sel_cppr;

  // lowest ring index wins; scan from the top so the lowest overwrites
  always_comb begin
    hit_o    = 1'b0;
    idx_o    = NONE;
    sel_cppr = '0;
    for (int r = int'(NUM_RINGS) - 1; r >= 0; r--) begin
      if (match_i[r]) begin
        hit_o    = 1'b1;
        idx_o    = IDX_W'(r);
        sel_cppr = cppr_i[r*PRIO_W +: PRIO_W];
      end
    end
  end

  assign prec_o = hit_o && !(prio_i < sel_cppr);
endmodule

// File: rtl/intr_ctx_matcher.sv
module intr_ctx_matcher
  import intr_ctx_matcher_pkg::*;
#(
  parameter int unsigned ID_W      = DEF_ID_W,
  parameter int unsigned PRIO_W    = DEF_PRIO_W,
  parameter int unsigned NUM_RINGS = DEF_RINGS,
  localparam int unsigned IDX_W    = $clog2(NUM_RINGS + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic                        fmt_i,
  input  logic                        ignore_i,
  input  logic [ID_W-1:0]             target_i,
  input  logic [PRIO_W-1:0]           prio_i,
  input  logic [NUM_RINGS-1:0]        ring_valid_i,
  input  logic [NUM_RINGS*ID_W-1:0]   ring_id_i,
  input  logic [NUM_RINGS*8-1:0]      ring_lgs_i,
  input  logic [NUM_RINGS*PRIO_W-1:0] ring_cppr_i,
  output logic                        out_valid,
  output logic                        hit_o,
  output logic [IDX_W-1:0]            ring_idx_o,
  output logic                        precluded_o
);
  localparam logic [IDX_W-1:0] NONE = IDX_W'(NUM_RINGS);

  logic [ID_W-1:0]      mask;
  logic [NUM_RINGS-1:0] match;
  logic                 grp;
  logic                 hit_d, prec_d;
  logic [IDX_W-1:0]     idx_d;
  logic                 vld_q, hit_q, prec_q;
  logic [IDX_W-1:0]     idx_q;

  assign grp = ignore_i && !fmt_i;

  icm_group_mask #(.ID_W(ID_W)) u_mask (
    .group_i  (grp),
    .target_i (target_i),
    .mask_o   (mask)
  );

  for (genvar r = 0; r < int'(NUM_RINGS); r++) begin : g_ring
    logic m;
    icm_ring_cmp #(.ID_W(ID_W), .PRIO_W(PRIO_W)) u_cmp (
      .group_i  (grp),
      .target_i (target_i),
      .mask_i   (mask),
      .valid_i  (ring_valid_i[r]),
      .id_i     (ring_id_i[r*ID_W +: ID_W]),
      .lgs_i    (ring_lgs_i[r*8 +: 8]),
      .match_o  (m)
    );
    // the user-level format is served elsewhere: no ring takes part
    assign match[r] = m && !fmt_i;
  end

  icm_ring_pick #(.NUM_RINGS(NUM_RINGS), .PRIO_W(PRIO_W)) u_pick (
    .match_i (match),
    .cppr_i  (ring_cppr_i),
    .prio_i  (prio_i),
    .hit_o   (hit_d),
    .idx_o   (idx_d),
    .prec_o  (prec_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      idx_q  <= NONE;
      prec_q <= 1'b0;
    end else if (in_valid) begin
      hit_q  <= hit_d;
      idx_q  <= idx_d;
      prec_q <= prec_d;
    end
  end

  assign out_valid   = vld_q;
  assign hit_o       = hit_q;
  assign ring_idx_o  = idx_q;
  assign precluded_o = prec_q;
endmodule

// File: rtl/intr_ctx_matcher_chk.sv
module intr_ctx_matcher_chk #(
  parameter int unsigned ID_W      = 32,
  parameter int unsigned PRIO_W    = 8,
  parameter int unsigned NUM_RINGS = 3,
  localparam int unsigned IDX_W    = $clog2(NUM_RINGS + 1)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        in_valid,
  input logic                        fmt_i,
  input logic                        ignore_i,
  input logic [ID_W-1:0]             target_i,
  input logic [PRIO_W-1:0]           prio_i,
  input logic [NUM_RINGS-1:0]        ring_valid_i,
  input logic [NUM_RINGS*ID_W-1:0]   ring_id_i,
  input logic                        out_valid,
  input logic                        hit_o,
  input logic [IDX_W-1:0]            ring_idx_o,
  input logic                        precluded_o
);
  // R7
  nomatch_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |-> (ring_idx_o == IDX_W'(NUM_RINGS)) && !precluded_o);

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(hit_o) && $stable(ring_idx_o) && $stable(precluded_o));

  // R10
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R8
  fmt_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && fmt_i |=> !hit_o);

  // R4
  invalid_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (ring_valid_i == '0) |=> !hit_o);

  // R6
  max_prio_prec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (prio_i == {PRIO_W{1'b1}}) |=> !hit_o || precluded_o);

  // R3
  phys_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !fmt_i && !ignore_i && ring_valid_i[0] &&
    (target_i == ring_id_i[ID_W-1:0]) |=> hit_o && (ring_idx_o == '0));
endmodule

bind intr_ctx_matcher intr_ctx_matcher_chk #(
  .ID_W(ID_W), .PRIO_W(PRIO_W), .NUM_RINGS(NUM_RINGS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt_i(fmt_i),
  .ignore_i(ignore_i), .target_i(target_i), .prio_i(prio_i),
  .ring_valid_i(ring_valid_i), .ring_id_i(ring_id_i),
  .out_valid(out_valid), .hit_o(hit_o), .ring_idx_o(ring_idx_o),
  .precluded_o(precluded_o)
);

// File: tb/intr_ctx_matcher_tb.sv
module intr_ctx_matcher_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, fmt_i, ignore_i;
  logic [31:0] target_i;
  logic [7:0]  prio_i;
  logic [2:0]  ring_valid_i;
  logic [95:0] ring_id_i;
  logic [23:0] ring_lgs_i, ring_cppr_i;
  logic        out_valid, hit_o, precluded_o;
  logic [1:0]  ring_idx_o;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  intr_ctx_matcher u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt_i(fmt_i),
    .ignore_i(ignore_i), .target_i(target_i), .prio_i(prio_i),
    .ring_valid_i(ring_valid_i), .ring_id_i(ring_id_i),
    .ring_lgs_i(ring_lgs_i), .ring_cppr_i(ring_cppr_i),
    .out_valid(out_valid), .hit_o(hit_o), .ring_idx_o(ring_idx_o),
    .precluded_o(precluded_o)
  );

  // reference: behavioural group mask from a count of low one bits
  function automatic logic [31:0] ref_mask(input logic ign, input logic [31:0] t);
    int ones = 0;
    logic [63:0] m;
    if (!ign) return 32'hFFFF_FFFF;
    while (ones < 32 && t[ones]) ones++;
    m = ~((64'd1 << (ones + 1)) - 64'd1);
    return m[31:0];
  endfunction

  task automatic check(input string tag, input logic eh, input logic [1:0] ei, input logic ep, input logic ev);
    n_vec++;
    if (hit_o !== eh || ring_idx_o !== ei || precluded_o !== ep || out_valid !== ev) begin
      n_bad++;
      $display("FAIL %s: got hit=%b idx=%0d prec=%b vld=%b, expected hit=%b idx=%0d prec=%b vld=%b",
               tag, hit_o, ring_idx_o, precluded_o, out_valid, eh, ei, ep, ev);
    end
  endtask

  task automatic apply(input string tag, input logic f, input logic ign, input logic [31:0] tgt,
                       input logic [7:0] pr, input logic [2:0] rv, input logic [95:0] ids,
                       input logic [23:0] lg, input logic [23:0] cp);
    logic       eh = 1'b0;
    logic [1:0] ei = 2'd3;
    logic       ep = 1'b0;
    logic [31:0] m = ref_mask(ign, tgt);
    if (!f) begin
      for (int r = 0; r < 3; r++) begin
        if (!eh && rv[r] && !(ign && lg[r*8 +: 8] == 8'd0) &&
            ((tgt & m) == (ids[r*32 +: 32] & m))) begin
          eh = 1'b1;
          ei = 2'(r);
          ep = !(pr < cp[r*8 +: 8]);
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b1; fmt_i = f; ignore_i = ign; target_i = tgt; prio_i = pr;
    ring_valid_i = rv; ring_id_i = ids; ring_lgs_i = lg; ring_cppr_i = cp;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, eh, ei, ep, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] t;
    logic [95:0] ids;
    rst_n = 1'b0; in_valid = 1'b0; fmt_i = 1'b0; ignore_i = 1'b0;
    target_i = '0; prio_i = '0; ring_valid_i = '0; ring_id_i = '0;
    ring_lgs_i = '0; ring_cppr_i = '0;
    repeat (3) @(negedge clk);
    check("R9 reset", 1'b0, 2'd3, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after reset", 1'b0, 2'd3, 1'b0, 1'b0);

    // R1 exact match on OS ring only
    apply("R1 exact os", 0, 0, 32'h1234_5678, 8'd1, 3'b111,
          {32'h1234_5678, 32'h0000_0001, 32'h0000_0002}, 24'h010101, 24'hFFFFFF);
    apply("R1 one-bit miss", 0, 0, 32'h1234_5678, 8'd1, 3'b111,
          {32'h1234_5679, 32'h1234_5670, 32'h0234_5678}, 24'h010101, 24'hFFFFFF);
    // R2 group mask: 0x13 has two low ones, bits 0..2 ignored
    apply("R2 group hit", 0, 1, 32'h0000_0013, 8'd0, 3'b001,
          {64'd0, 32'h0000_0010}, 24'h000001, 24'h000010);
    apply("R2 group miss bit3", 0, 1, 32'h0000_0013, 8'd0, 3'b001,
          {64'd0, 32'h0000_0018}, 24'h000001, 24'h000010);
    apply("R2 all ones", 0, 1, 32'hFFFF_FFFF, 8'd0, 3'b100,
          {32'h8765_4321, 64'd0}, 24'h010000, 24'h100000);
    apply("R2 even target", 0, 1, 32'h0000_00A0, 8'd0, 3'b010,
          {32'd0, 32'h0000_00A1, 32'd0}, 24'h000100, 24'h001000);
    // R3 all rings match
    apply("R3 phys first", 0, 0, 32'hCAFE_0001, 8'd2, 3'b111,
          {3{32'hCAFE_0001}}, 24'h010101, 24'h030303);
    apply("R3 pool second", 0, 0, 32'hCAFE_0001, 8'd2, 3'b110,
          {3{32'hCAFE_0001}}, 24'h010101, 24'h030303);
    // R4 valid bit required
    apply("R4 invalid rings", 0, 0, 32'hCAFE_0001, 8'd2, 3'b000,
          {3{32'hCAFE_0001}}, 24'h010101, 24'h030303);
    // R5 group skips zero enable; exact does not care
    apply("R5 lgs skip", 0, 1, 32'h0000_0013, 8'd2, 3'b111,
          {3{32'h0000_0010}}, 24'h010200, 24'h090909);
    apply("R5 all lgs zero", 0, 1, 32'h0000_0013, 8'd2, 3'b111,
          {3{32'h0000_0010}}, 24'h000000, 24'h090909);
    apply("R5 exact ignores lgs", 0, 0, 32'h0000_0013, 8'd2, 3'b111,
          {3{32'h0000_0013}}, 24'h000000, 24'h090909);
    // R6 preclusion boundary
    apply("R6 below", 0, 0, 32'h55, 8'd5, 3'b001, {64'd0, 32'h55}, 24'h1, 24'h06);
    apply("R6 equal", 0, 0, 32'h55, 8'd6, 3'b001, {64'd0, 32'h55}, 24'h1, 24'h06);
    apply("R6 above", 0, 0, 32'h55, 8'd7, 3'b001, {64'd0, 32'h55}, 24'h1, 24'h06);
    // R7 nothing matches, max priority
    apply("R7 no match", 0, 1, 32'h0000_0000, 8'hFF, 3'b111,
          {32'h2, 32'h3, 32'h4}, 24'hFFFFFF, 24'h000000);
    // R8 format bit
    apply("R8 format", 1, 0, 32'h77, 8'd0, 3'b111, {3{32'h77}}, 24'hFFFFFF, 24'hFFFFFF);
    apply("R8 format group", 1, 1, 32'h77, 8'd0, 3'b111, {3{32'h70}}, 24'hFFFFFF, 24'hFFFFFF);

    // R10 hold with idle strobe and changed inputs
    apply("R10 load", 0, 0, 32'h99, 8'd1, 3'b010, {32'd0, 32'h99, 32'd0}, 24'h0, 24'h000200);
    @(negedge clk);
    target_i = 32'h0; ring_valid_i = 3'b000; fmt_i = 1'b1;
    @(negedge clk);
    check("R10 hold", 1'b1, 2'd1, 1'b0, 1'b0);

    // random vectors, ids derived from the target to reach hits
    for (int k = 0; k < 400; k++) begin
      t = $urandom;
      if (k % 3 == 0) t = t | 32'h0000_00FF >> ($urandom % 8);
      for (int r = 0; r < 3; r++)
        ids[r*32 +: 32] = ($urandom % 2) ? (t ^ (32'($urandom % 16))) : $urandom;
      apply("R1 R2 R3 R5 R6 random", ($urandom % 8) == 0, $urandom % 2, t, 8'($urandom),
            3'($urandom), ids, ($urandom % 2) ? 24'($urandom) : 24'($urandom) & 24'h00FF00,
            24'($urandom));
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule